// File: doc/BRIEF.md
# Flow-Through Burst SRAM Core

This block is a small synchronous static memory with no output register stage. Each word has four lanes of nine bits, and the top bit of each lane is a parity bit. An external burst sequencer supplies the address on every cycle, together with a select and a strobe. The select means the device is addressed in that cycle. The strobe marks the first beat of a new access. The block captures the address at the rising clock edge. Read data then appears in the same cycle, combinationally from the captured address, so a burst runs at a 2-1-1-1 rhythm. Writes take place at the clock edge that captures the address. An active-low global write and an active-low byte-write enable decide which lanes are stored, together with four active-low lane selects.

The shared data bus is split into a write-data port, a read-data port and a drive-enable output. The drive enable follows the active-low output enable asynchronously. It is suppressed whenever a write is requested, whenever the device is deselected, and after any write until a strobed read starts again. An asynchronous sleep input passes through a two-stage synchronizer. From the moment the sleep input rises until two clock edges after it falls, every access is ignored and the array contents are kept. The bus is released as soon as the sleep input rises and is still released when sleep ends.

Top module: `sram_ft_core`

## Requirements
- R1: While rst_n is low, rd_drive is low.
- R2: Consider a read (acc_sel=1, gw_n=1, bwe_n=1) presented at a clock edge with acc_strobe=1. After that same edge, rd_data shows the word at that address and rd_drive is high, provided oe_n is low. A following read with acc_strobe=0 moves rd_data to the new address in its own cycle and keeps rd_drive high.
- R3: With acc_sel=1 and gw_n=0 at an edge, all 36 bits of wr_data are stored, whatever bwe_n and bw_n are.
- R4: With gw_n=1 and bwe_n=0, lane i (bits 9*i+8 down to 9*i, where bit 9*i+8 is its parity bit) is stored exactly when bw_n[i]=0. All other lanes keep their old contents, and the parity bit follows its lane.
- R5: With gw_n=1 and bwe_n=1 the cycle is a read, and the array does not change, whatever is on wr_data.
- R6: oe_n high forces rd_drive low with no clock edge needed. oe_n low again restores rd_drive.
- R7: While acc_sel=1 and either gw_n=0 or bwe_n=0, rd_drive is low even before the edge.
- R8: After a write edge, rd_drive stays low through reads with acc_strobe=0. It rises only after a strobed read.
- R9: An edge with acc_sel=0 deselects the device, and rd_drive is low in the cycle that follows.
- R10: While zz is high, rd_drive is low at once. Writes at edges during zz high, and at the first two edges after zz falls, are ignored. rd_drive is still low after those two edges, and an access at the third edge is accepted.
- R11: Array contents are kept across a sleep period.
- R12: gw_n=1, bwe_n=0 and bw_n=4'b1111 form a write cycle that stores nothing. rd_drive is low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 4 | Word address from the burst sequencer |
| acc_sel | input | 1 | Device selected in this cycle |
| acc_strobe | input | 1 | First beat of a new access |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| wr_data | input | 36 | Write data, four 9-bit lanes |
| rd_data | output | 36 | Flow-through read data |
| rd_drive | output | 1 | Drive enable for the shared bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Asynchronous sleep request |

## Verification
Writes are driven in three forms: global-write with conflicting lane selects, masked lane patterns that include all lanes and no lanes, and an all-ones word stored over an all-zero word. These show whether the global path overrides the lane path and whether each parity bit moves with its own lane. Reads come both strobed and as burst continuations. Some follow a read and some follow a write, which checks same-cycle data against a one-cycle-late output and shows that only a strobe re-arms the bus after a write. Output enable, write requests and sleep are toggled between edges to check that the driver reacts combinationally. Write attempts are placed in each of the two exit cycles of sleep to measure the exact length of the exit window.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/sram_ft_sleep_sync.sv
module sram_ft_sleep_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic zz,
  output logic blk
);

  logic z1_q, z2_q;
  logic z1_d, z2_d;

  always_comb begin
    z1_d = zz;
    z2_d = z1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z1_q <= 1'b0;
      z2_q <= 1'b0;
    end else begin
      z1_q <= z1_d;
      z2_q <= z2_d;
    end
  end

  // blocked from the raw request until the second stage clears
  assign blk = zz | z1_q | z2_q;

endmodule

// File: rtl/sram_ft_wr_decode.sv
module sram_ft_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic             is_write,
  output logic [LANES-1:0] lane_we
);

  always_comb begin
    is_write = !gw_n || !bwe_n;
    for (int i = 0; i < LANES; i++) begin
      if (!gw_n)       lane_we[i] = 1'b1;
      else if (!bwe_n) lane_we[i] = !bw_n[i];
      else             lane_we[i] = 1'b0;
    end
  end

endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/sram_ft_core.sv
module sram_ft_core
  import sram_ft_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_sel,
  input  logic             acc_strobe,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive,
  input  logic             oe_n,
  input  logic             zz
);

  logic             blk;
  logic             is_write;
  logic [LANES-1:0] lane_we;
  logic [LANES-1:0] lane_we_g;
  logic             wr_req;
  acc_kind_e        kind;

  logic [AW-1:0]    addr_q, addr_d;
  logic             rd_act_q, rd_act_d;

  sram_ft_sleep_sync i_sleep (
    .clk   (clk),
    .rst_n (rst_n),
    .zz    (zz),
    .blk   (blk)
  );

  sram_ft_wr_decode #(.LANES(LANES)) i_dec (
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .is_write (is_write),
    .lane_we  (lane_we)
  );

  // classify the access presented for the coming edge
  always_comb begin
    if (blk || !acc_sel) kind = ACC_IDLE;
    else if (is_write)   kind = ACC_WRITE;
    else                 kind = ACC_READ;
  end

  assign wr_req    = acc_sel && is_write;
  assign lane_we_g = (kind == ACC_WRITE) ? lane_we : '0;

  always_comb begin
    addr_d   = addr_q;
    rd_act_d = rd_act_q;
    case (kind)
      ACC_READ: begin
        addr_d = acc_addr;
        if (acc_strobe) rd_act_d = 1'b1;
      end
      ACC_WRITE: begin
        addr_d   = acc_addr;
        rd_act_d = 1'b0;
      end
      default: rd_act_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      rd_act_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      rd_act_q <= rd_act_d;
    end
  end

  sram_ft_array #(
    .DEPTH  (DEPTH),
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .AW     (AW)
  ) i_array (
    .clk   (clk),
    .we    (lane_we_g),
    .waddr (acc_addr),
    .wdata (wr_data),
    .raddr (addr_q),
    .rdata (rd_data)
  );

  assign rd_drive = !oe_n && rd_act_q && !wr_req && !blk;

endmodule

// File: rtl/sram_ft_core_chk.sv
module sram_ft_core_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_sel,
  input logic          acc_strobe,
  input logic          gw_n,
  input logic          bwe_n,
  input logic          oe_n,
  input logic          zz,
  input logic          rd_drive,
  input logic [DW-1:0] rd_data,
  input logic          blk,
  input logic          wr_req
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !rd_drive);

  p_read_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && acc_strobe && gw_n && bwe_n && !blk) |=> (rd_drive || oe_n || wr_req || blk));

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_drive);

  p_wr_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !rd_drive);

  p_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !blk) |=> !rd_drive);

  p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_sel |=> !rd_drive);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (zz || blk) |-> !rd_drive);

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> $stable(rd_data));

endmodule

bind sram_ft_core sram_ft_core_chk #(.DW(LANES*LANE_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_sel    (acc_sel),
  .acc_strobe (acc_strobe),
  .gw_n       (gw_n),
  .bwe_n      (bwe_n),
  .oe_n       (oe_n),
  .zz         (zz),
  .rd_drive   (rd_drive),
  .rd_data    (rd_data),
  .blk        (blk),
  .wr_req     (wr_req)
);

// File: tb/test_sram_ft_core.sv
`timescale 1ns/1ps
module test_sram_ft_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  acc_addr;
  logic        acc_sel, acc_strobe, gw_n, bwe_n;
  logic [3:0]  bw_n;
  logic [35:0] wr_data;
  logic [35:0] rd_data;
  logic        rd_drive;
  logic        oe_n, zz;

  logic [35:0] model [16];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sram_ft_core i_sram_ft_core (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_sel(acc_sel),
    .acc_strobe(acc_strobe), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive),
    .oe_n(oe_n), .zz(zz)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic stb, input logic gw, input logic bwe,
                     input logic [3:0] bw, input logic [3:0] a, input logic [35:0] d);
    acc_sel = sel; acc_strobe = stb; gw_n = gw; bwe_n = bwe;
    bw_n = bw; acc_addr = a; wr_data = d;
  endtask

  task automatic idle();
    put(1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 4'h0, 36'h0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] bw);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!bw[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic strobed_read(input logic [3:0] a, input string req);
    put(1'b1, 1'b1, 1'b1, 1'b1, 4'hF, a, 36'h0);
    step();
    chk({req, " read data"}, rd_data, model[a]);
    chk({req, " read drive"}, {35'h0, rd_drive}, 36'h1);
  endtask

  task automatic t_reset();
    chk("R1 drive in reset", {35'h0, rd_drive}, 36'h0);
  endtask

  task automatic t_full_write();
    put(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd3, 36'hA_5A5A_5A5A);
    step(); model[3] = 36'hA_5A5A_5A5A;
    put(1'b1, 1'b1, 1'b0, 1'b0, 4'b1010, 4'd5, 36'h0_0000_0000);
    step(); model[5] = 36'h0;
    put(1'b1, 1'b1, 1'b0, 1'b0, 4'b0101, 4'd6, 36'h1_2345_6789);
    step(); model[6] = 36'h1_2345_6789;
    strobed_read(4'd3, "R3");
    strobed_read(4'd5, "R3");
    strobed_read(4'd6, "R3");
  endtask

  task automatic t_byte_write();
    put(1'b1, 1'b1, 1'b1, 1'b0, 4'b1010, 4'd5, 36'hF_FFFF_FFFF);
    step(); model[5] = merge(model[5], 36'hF_FFFF_FFFF, 4'b1010);
    strobed_read(4'd5, "R4");
    chk("R4 lane0/2 ones incl parity", model[5], 36'h0_07FC_01FF);
    put(1'b1, 1'b1, 1'b1, 1'b0, 4'b0111, 4'd3, 36'h8_0000_0000);
    step(); model[3] = merge(model[3], 36'h8_0000_0000, 4'b0111);
    strobed_read(4'd3, "R4 parity lane3");
    put(1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, 4'd6, 36'hE_DCBA_9876);
    step(); model[6] = 36'hE_DCBA_9876;
    strobed_read(4'd6, "R4 all lanes");
  endtask

  task automatic t_empty_write();
    put(1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 4'd6, 36'h0_1111_1111);
    step();
    chk("R12 drive after empty write", {35'h0, rd_drive}, 36'h0);
    strobed_read(4'd6, "R12 unchanged");
  endtask

  task automatic t_read_only();
    put(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'd5, 36'h3_3333_3333);
    step();
    chk("R5 read with data on bus", rd_data, model[5]);
    strobed_read(4'd5, "R5 unchanged");
  endtask

  task automatic t_flow();
    strobed_read(4'd3, "R2 first beat");
    put(1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 4'd6, 36'h0);
    step();
    chk("R2 burst beat data", rd_data, model[6]);
    chk("R2 burst beat drive", {35'h0, rd_drive}, 36'h1);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #1;
    chk("R6 oe high releases", {35'h0, rd_drive}, 36'h0);
    oe_n = 1'b0; #1;
    chk("R6 oe low restores", {35'h0, rd_drive}, 36'h1);
  endtask

  task automatic t_mask_and_rearm();
    put(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd9, 36'h5_0505_0505); #1;
    chk("R7 write request masks", {35'h0, rd_drive}, 36'h0);
    put(1'b1, 1'b1, 1'b1, 1'b0, 4'b1110, 4'd9, 36'h5_0505_0505); #1;
    chk("R7 byte write request masks", {35'h0, rd_drive}, 36'h0);
    put(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd9, 36'h5_0505_0505);
    step(); model[9] = 36'h5_0505_0505;
    put(1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 4'd9, 36'h0); #1;
    chk("R7 after write edge", {35'h0, rd_drive}, 36'h0);
    step();
    chk("R8 unstrobed read stays off", {35'h0, rd_drive}, 36'h0);
    chk("R8 unstrobed data", rd_data, model[9]);
    strobed_read(4'd9, "R8 strobe rearms");
  endtask

  task automatic t_deselect();
    idle();
    step();
    chk("R9 deselected", {35'h0, rd_drive}, 36'h0);
  endtask

  task automatic t_sleep();
    strobed_read(4'd3, "R10 setup");
    idle(); zz = 1'b1; #1;
    chk("R10 zz releases at once", {35'h0, rd_drive}, 36'h0);
    step(); step();
    put(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd3, 36'h0_DEAD_BEEF);
    step();
    put(1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 36'h0);
    step();
    chk("R10 read ignored asleep", {35'h0, rd_drive}, 36'h0);
    zz = 1'b0;
    put(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd3, 36'h0_1234_0000);
    step();
    put(1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 4'd3, 36'h0_0000_4321);
    step();
    put(1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 36'h0); #1;
    chk("R10 still off after exit", {35'h0, rd_drive}, 36'h0);
    step();
    chk("R11 retained across sleep", rd_data, model[3]);
    chk("R10 access after exit", {35'h0, rd_drive}, 36'h1);
  endtask

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; zz = 1'b0;
    idle();
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_write();
    t_byte_write();
    t_empty_write();
    t_read_only();
    t_flow();
    t_oe();
    t_mask_and_rearm();
    t_deselect();
    t_sleep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule